// File: doc/BRIEF.md
# SPI FIFO and Interrupt Status Unit

This unit sits between an SPI controller's register interface and its serial shift engine. It holds one transmit word queue, filled by the host and drained by the shift engine, and one receive word queue, filled by the shift engine and drained by the host. It reports each queue's fill level and compares the levels against programmable thresholds. The threshold results drive DMA request lines and also feed a latched status word. Six event sources are captured there, and each can be cleared by writing 1 to its bit. A per-source enable mask combines the captured bits into one interrupt line.

Host-side data moves over valid/ready handshakes. A host word enters the transmit queue only when `tx_wr_valid` and `tx_wr_ready` are both high, and `tx_wr_ready` drops while the queue is full. A received word leaves on `rx_rd_valid && rx_rd_ready`. On the engine side, the engine takes a transmit word when it raises `eng_tx_ready`. The engine cannot be stalled, so a received word arrives with a single-cycle `eng_rx_valid` pulse and has no ready signal. The engine's missed words are reported as underrun and overrun events. Each queue can be flushed on its own. The depth is reported as a size code n, where depth = 2 << n words.

Top module: `spiq_fifo_irq`

## Requirements
- R1: While reset is asserted, both levels read 0, the status word reads 0 and `irq` is low.
- R2: The transmit queue returns host words to the engine in push order, and its level follows pushes and pops. `tx_wr_ready` is low while the level equals the depth, and a host word offered then is not stored.
- R3: The receive queue returns engine words to the host in arrival order, and `rx_rd_valid` is high exactly when its level is nonzero.
- R4: An engine word arriving while the receive level equals the depth is discarded, even if the host pops in the same cycle, and status bit 0 (receive overrun) is set at that clock edge.
- R5: `eng_tx_ready` while the transmit queue is empty sets status bit 1 (transmit underrun) at that edge and leaves the level at 0.
- R6: The receive threshold hit is rx_level >= min(rx_thresh, depth). It drives `rx_dma_req` combinationally and sets status bit 2 one clock after the level reaches it.
- R7: The transmit threshold hit is tx_level <= tx_thresh. It drives `tx_dma_req` combinationally and sets status bit 3 one clock later.
- R8: A `xfer_end` pulse sets status bit 4, and a `slv_cmd` pulse sets status bit 5, both at the edge where the pulse is high.
- R9: A `sts_clr_we` cycle clears every status bit whose `sts_clr_data` bit is 1 and leaves the bits written with 0 unchanged. A source that sets in the same cycle wins over the clear, and a set bit stays set until it is cleared.
- R10: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.
- R11: Each DMA request is its enable ANDed with the live threshold hit. Clearing status bits does not affect the requests.
- R12: A flush pulse empties its queue at the next edge and discards any push in the same cycle.
- R13: `fifo_size_code` equals DEPTH_LOG2-1, so that 2 << code gives the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr_valid | input | 1 | Host offers a transmit word |
| tx_wr_ready | output | 1 | Transmit queue can accept a word |
| tx_wr_data | input | DATA_W | Transmit word from host |
| eng_tx_valid | output | 1 | Transmit queue holds a word for the engine |
| eng_tx_ready | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | DATA_W | Head transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word from engine |
| rx_rd_valid | output | 1 | Receive queue holds a word for the host |
| rx_rd_ready | input | 1 | Host takes the head receive word |
| rx_rd_data | output | DATA_W | Head receive word |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| tx_thresh | input | DEPTH_LOG2+1 | Transmit threshold level |
| rx_thresh | input | DEPTH_LOG2+1 | Receive threshold level |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| xfer_end | input | 1 | End-of-transfer event pulse |
| slv_cmd | input | 1 | Target-mode command received pulse |
| irq_en | input | 6 | Per-source interrupt enable |
| sts_clr_we | input | 1 | Status write strobe (write 1 to clear) |
| sts_clr_data | input | 6 | Status bits to clear |
| sts_q | output | 6 | Latched status word |
| irq | output | 1 | Interrupt line |
| tx_level | output | DEPTH_LOG2+1 | Transmit queue fill level |
| rx_level | output | DEPTH_LOG2+1 | Receive queue fill level |
| fifo_size_code | output | 4 | Depth code n, depth = 2 << n |

## Verification
The bench fills each queue to its depth. A design that let the full boundary slip would store a ninth transmit word or let a late receive word overwrite the oldest one, and the read-back order would then show a foreign or missing value. It pops the empty transmit queue and pushes into the full receive queue. A design that got these wrong would move a level past a bound or fail to raise the overrun or underrun bit. It clears a status bit in the same cycle its source fires, writes zeros to the clear port, and sets a receive threshold above the depth. A wrong priority would lose an event, a non-masked clear would wipe unrelated bits, and a missing clamp would leave the receive request silent even with a full queue.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int NSRC         = 6;
  localparam int SRC_RX_OVR   = 0;
  localparam int SRC_TX_UDR   = 1;
  localparam int SRC_RX_THR   = 2;
  localparam int SRC_TX_THR   = 3;
  localparam int SRC_XFER_END = 4;
  localparam int SRC_SLV_CMD  = 5;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   level
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W:0]   count;
  logic              push_ok, pop_ok;

  assign full    = (count == (ADDR_W+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign head    = mem[rd_ptr];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spiq_level_cmp.sv
module spiq_level_cmp #(
  parameter int ADDR_W = 3,
  parameter bit IS_RX  = 1'b1
) (
  input  logic [ADDR_W:0] level,
  input  logic [ADDR_W:0] thresh,
  output logic            hit
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  generate
    if (IS_RX) begin : g_rx
      logic [CNT_W-1:0] eff_thresh;
      // a threshold above the depth behaves as the depth
      assign eff_thresh = (thresh > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : thresh;
      assign hit = (level >= eff_thresh);
    end else begin : g_tx
      assign hit = (level <= thresh);
    end
  endgenerate
endmodule

// File: rtl/spiq_status.sv
module spiq_status
  import spiq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_set,
  input  logic     clr_we,
  input  src_vec_t clr_data,
  input  src_vec_t irq_en,
  output src_vec_t sts_q,
  output logic     irq
);
  src_vec_t clr_mask;
  assign clr_mask = {NSRC{clr_we}} & clr_data;

  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sts_q[b] <= 1'b0;
        else if (evt_set[b]) sts_q[b] <= 1'b1;
        else if (clr_mask[b]) sts_q[b] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(sts_q & irq_en);
endmodule

// File: rtl/spiq_fifo_irq.sv
module spiq_fifo_irq
  import spiq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_wr_valid,
  output logic                  tx_wr_ready,
  input  logic [DATA_W-1:0]     tx_wr_data,
  output logic                  eng_tx_valid,
  input  logic                  eng_tx_ready,
  output logic [DATA_W-1:0]     eng_tx_data,
  input  logic                  eng_rx_valid,
  input  logic [DATA_W-1:0]     eng_rx_data,
  output logic                  rx_rd_valid,
  input  logic                  rx_rd_ready,
  output logic [DATA_W-1:0]     rx_rd_data,
  input  logic                  tx_flush,
  input  logic                  rx_flush,
  input  logic [DEPTH_LOG2:0]   tx_thresh,
  input  logic [DEPTH_LOG2:0]   rx_thresh,
  input  logic                  tx_dma_en,
  input  logic                  rx_dma_en,
  output logic                  tx_dma_req,
  output logic                  rx_dma_req,
  input  logic                  xfer_end,
  input  logic                  slv_cmd,
  input  logic [NSRC-1:0]       irq_en,
  input  logic                  sts_clr_we,
  input  logic [NSRC-1:0]       sts_clr_data,
  output logic [NSRC-1:0]       sts_q,
  output logic                  irq,
  output logic [DEPTH_LOG2:0]   tx_level,
  output logic [DEPTH_LOG2:0]   rx_level,
  output logic [3:0]            fifo_size_code
);
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_hit, rx_hit;
  src_vec_t evt_set;

  spiq_fifo #(.DATA_W(DATA_W), .ADDR_W(DEPTH_LOG2)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr_valid), .push_data(tx_wr_data), .pop(eng_tx_ready),
    .head(eng_tx_data), .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  spiq_fifo #(.DATA_W(DATA_W), .ADDR_W(DEPTH_LOG2)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_valid), .push_data(eng_rx_data), .pop(rx_rd_ready),
    .head(rx_rd_data), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  spiq_level_cmp #(.ADDR_W(DEPTH_LOG2), .IS_RX(1'b0)) u_tx_cmp (
    .level(tx_level), .thresh(tx_thresh), .hit(tx_hit)
  );

  spiq_level_cmp #(.ADDR_W(DEPTH_LOG2), .IS_RX(1'b1)) u_rx_cmp (
    .level(rx_level), .thresh(rx_thresh), .hit(rx_hit)
  );

  always_comb begin
    evt_set               = '0;
    evt_set[SRC_RX_OVR]   = eng_rx_valid & rx_full;
    evt_set[SRC_TX_UDR]   = eng_tx_ready & tx_empty;
    evt_set[SRC_RX_THR]   = rx_hit;
    evt_set[SRC_TX_THR]   = tx_hit;
    evt_set[SRC_XFER_END] = xfer_end;
    evt_set[SRC_SLV_CMD]  = slv_cmd;
  end

  spiq_status u_status (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .clr_we(sts_clr_we), .clr_data(sts_clr_data), .irq_en(irq_en),
    .sts_q(sts_q), .irq(irq)
  );

  assign tx_wr_ready    = ~tx_full;
  assign eng_tx_valid   = ~tx_empty;
  assign rx_rd_valid    = ~rx_empty;
  assign tx_dma_req     = tx_dma_en & tx_hit;
  assign rx_dma_req     = rx_dma_en & rx_hit;
  assign fifo_size_code = 4'(DEPTH_LOG2 - 1);
endmodule

// File: rtl/spiq_fifo_irq_chk.sv
module spiq_fifo_irq_chk #(
  parameter int DEPTH_LOG2 = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_wr_ready,
  input logic                eng_tx_ready,
  input logic                eng_rx_valid,
  input logic                rx_rd_ready,
  input logic                tx_flush,
  input logic                rx_flush,
  input logic                xfer_end,
  input logic                sts_clr_we,
  input logic [5:0]          sts_clr_data,
  input logic [5:0]          sts_q,
  input logic [DEPTH_LOG2:0] tx_level,
  input logic [DEPTH_LOG2:0] rx_level
);
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(1 << DEPTH_LOG2);

  logic [5:0] clr_mask;
  assign clr_mask = {6{sts_clr_we}} & sts_clr_data;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL_LVL) && (rx_level <= FULL_LVL)); // R2

  AST_TX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == FULL_LVL) |-> !tx_wr_ready); // R2

  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_level == FULL_LVL) |=> sts_q[0]); // R4

  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_level == FULL_LVL && !rx_rd_ready && !rx_flush) |=> (rx_level == FULL_LVL)); // R4

  AST_UDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_ready && tx_level == '0 && !tx_flush) |=> (sts_q[1] && tx_level == '0)); // R5

  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> sts_q[4]); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sts_q) & ~$past(clr_mask)) & ~sts_q) == 6'b0); // R9

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_level == '0)); // R12

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_level == '0)); // R12
endmodule

bind spiq_fifo_irq spiq_fifo_irq_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_ready(tx_wr_ready),
  .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid),
  .rx_rd_ready(rx_rd_ready), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .xfer_end(xfer_end), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
  .sts_q(sts_q), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spiq_fifo_irq_tb_top.sv
module spiq_fifo_irq_tb_top;
  localparam int DATA_W = 32;
  localparam int DL2    = 3;
  localparam int DEPTH  = 1 << DL2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              tx_wr_valid = 0, eng_tx_ready = 0, eng_rx_valid = 0, rx_rd_ready = 0;
  logic [DATA_W-1:0] tx_wr_data = '0, eng_rx_data = '0;
  logic              tx_flush = 0, rx_flush = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [DL2:0]      tx_thresh = 4'd2, rx_thresh = 4'd4;
  logic              xfer_end = 0, slv_cmd = 0, sts_clr_we = 0;
  logic [5:0]        irq_en = '0, sts_clr_data = '0;
  logic              tx_wr_ready, eng_tx_valid, rx_rd_valid, tx_dma_req, rx_dma_req, irq;
  logic [DATA_W-1:0] eng_tx_data, rx_rd_data;
  logic [5:0]        sts_q;
  logic [DL2:0]      tx_level, rx_level;
  logic [3:0]        fifo_size_code;

  spiq_fifo_irq #(.DATA_W(DATA_W), .DEPTH_LOG2(DL2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready), .tx_wr_data(tx_wr_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .rx_rd_valid(rx_rd_valid), .rx_rd_ready(rx_rd_ready), .rx_rd_data(rx_rd_data),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .xfer_end(xfer_end), .slv_cmd(slv_cmd),
    .irq_en(irq_en), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .sts_q(sts_q), .irq(irq),
    .tx_level(tx_level), .rx_level(rx_level), .fifo_size_code(fifo_size_code)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {push, pop, data, expected level, expected head}
  localparam logic [69:0] TX_VEC [9] = '{
    {1'b1, 1'b0, 32'h1111_1111, 4'd1, 32'h1111_1111},
    {1'b1, 1'b0, 32'h2222_2222, 4'd2, 32'h1111_1111},
    {1'b1, 1'b1, 32'h3333_3333, 4'd2, 32'h2222_2222},
    {1'b0, 1'b1, 32'h0000_0000, 4'd1, 32'h3333_3333},
    {1'b1, 1'b0, 32'h4444_4444, 4'd2, 32'h3333_3333},
    {1'b0, 1'b1, 32'h0000_0000, 4'd1, 32'h4444_4444},
    {1'b0, 1'b1, 32'h0000_0000, 4'd0, 32'h0000_0000},
    {1'b1, 1'b0, 32'h5555_5555, 4'd1, 32'h5555_5555},
    {1'b0, 1'b1, 32'h0000_0000, 4'd0, 32'h0000_0000}
  };
  logic [69:0] v;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [31:0] d);
    tx_wr_valid = 1; tx_wr_data = d; tick(); tx_wr_valid = 0;
  endtask

  task automatic pop_tx();
    eng_tx_ready = 1; tick(); eng_tx_ready = 0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    eng_rx_valid = 1; eng_rx_data = d; tick(); eng_rx_valid = 0;
  endtask

  task automatic clr(input logic [5:0] m);
    sts_clr_we = 1; sts_clr_data = m; tick(); sts_clr_we = 0; sts_clr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R1 / R13: reset state
    chk("R1 tx_level in reset", 32'(tx_level), 0);
    chk("R1 rx_level in reset", 32'(rx_level), 0);
    chk("R1 sts_q in reset", 32'(sts_q), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R13 size code", 32'(fifo_size_code), DL2 - 1);
    rst_n = 1;
    tick();
    chk("R7 tx threshold bit after reset", 32'(sts_q[3]), 1);
    clr(6'h3F);
    chk("R9 set wins over clear", 32'(sts_q[3]), 1);

    // R2: vector table on the transmit path
    for (int i = 0; i < 9; i++) begin
      v = TX_VEC[i];
      tx_wr_valid = v[69]; tx_wr_data = v[67:36]; eng_tx_ready = v[68];
      tick();
      tx_wr_valid = 0; eng_tx_ready = 0;
      chk("R2 table tx_level", 32'(tx_level), 32'(v[35:32]));
      chk("R2 table eng_tx_valid", 32'(eng_tx_valid), 32'(v[35:32] != 0));
      if (v[35:32] != 0) chk("R2 table head", eng_tx_data, v[31:0]);
    end
    chk("R5 no underrun from table", 32'(sts_q[1]), 0);

    // R2: fill to depth, back-pressure
    for (int i = 0; i < DEPTH; i++) push_tx(32'hC000_0000 + i);
    chk("R2 tx full level", 32'(tx_level), DEPTH);
    chk("R2 tx_wr_ready low when full", 32'(tx_wr_ready), 0);
    push_tx(32'hDEAD_BEEF);
    chk("R2 push while full ignored", 32'(tx_level), DEPTH);
    tx_dma_en = 1;
    #1 chk("R11 tx_dma_req off above thresh", 32'(tx_dma_req), 0);
    clr(6'h08);
    chk("R7 tx threshold bit clears when above", 32'(sts_q[3]), 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 tx order", eng_tx_data, 32'hC000_0000 + i);
      pop_tx();
    end
    chk("R2 tx empty after drain", 32'(tx_level), 0);
    chk("R11 tx_dma_req on at low level", 32'(tx_dma_req), 1);

    // R5 underrun, R9 write-one-to-clear
    pop_tx();
    chk("R5 underrun bit", 32'(sts_q[1]), 1);
    chk("R5 level stays 0", 32'(tx_level), 0);
    clr(6'h00);
    chk("R9 write of zeros keeps bit", 32'(sts_q[1]), 1);
    clr(6'h02);
    chk("R9 write of one clears bit", 32'(sts_q[1]), 0);
    pop_tx();

    // R10 interrupt masking
    irq_en = 6'b000000; #1;
    chk("R10 irq masked", 32'(irq), 0);
    irq_en = 6'b000010; #1;
    chk("R10 irq enabled source", 32'(irq), 1);
    irq_en = 6'b000001; #1;
    chk("R10 irq other source idle", 32'(irq), 0);
    irq_en = 6'b000000;

    // R6 receive threshold, R3 order, R4 overrun
    rx_dma_en = 1;
    for (int i = 0; i < 3; i++) push_rx(32'hA000_0000 + i);
    chk("R6 rx_dma_req below thresh", 32'(rx_dma_req), 0);
    tick();
    chk("R6 rx threshold bit below", 32'(sts_q[2]), 0);
    push_rx(32'hA000_0003);
    chk("R6 rx_dma_req at thresh", 32'(rx_dma_req), 1);
    tick();
    chk("R6 rx threshold bit at thresh", 32'(sts_q[2]), 1);
    for (int i = 4; i < DEPTH; i++) push_rx(32'hA000_0000 + i);
    chk("R4 no overrun before full", 32'(sts_q[0]), 0);
    rx_rd_ready = 1;
    push_rx(32'h0000_0BAD);
    rx_rd_ready = 0;
    chk("R4 overrun bit", 32'(sts_q[0]), 1);
    chk("R4 dropped word, one popped", 32'(rx_level), DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      chk("R3 rx_rd_valid", 32'(rx_rd_valid), 1);
      chk("R3 rx order", rx_rd_data, 32'hA000_0000 + i);
      rx_rd_ready = 1; tick(); rx_rd_ready = 0;
    end
    chk("R3 rx empty", 32'(rx_rd_valid), 0);

    // R6 clamp of threshold above depth
    rx_thresh = 4'd15;
    for (int i = 0; i < DEPTH - 1; i++) push_rx(i);
    chk("R6 clamp not hit below depth", 32'(rx_dma_req), 0);
    push_rx(32'h77);
    chk("R6 clamp hit at depth", 32'(rx_dma_req), 1);

    // R12 flush
    rx_flush = 1; eng_rx_valid = 1; eng_rx_data = 32'h99; tick();
    rx_flush = 0; eng_rx_valid = 0;
    chk("R12 rx flushed", 32'(rx_level), 0);
    chk("R12 rx push with flush dropped", 32'(rx_rd_valid), 0);
    for (int i = 0; i < 3; i++) push_tx(i);
    tx_flush = 1; tick(); tx_flush = 0;
    chk("R12 tx flushed", 32'(tx_level), 0);
    chk("R12 tx valid low", 32'(eng_tx_valid), 0);

    // R8 events, R9 priority
    xfer_end = 1; tick(); xfer_end = 0;
    chk("R8 end-of-transfer bit", 32'(sts_q[4]), 1);
    slv_cmd = 1; tick(); slv_cmd = 0;
    chk("R8 command bit", 32'(sts_q[5]), 1);
    xfer_end = 1; sts_clr_we = 1; sts_clr_data = 6'h10; tick();
    xfer_end = 0; sts_clr_we = 0; sts_clr_data = '0;
    chk("R9 event beats clear", 32'(sts_q[4]), 1);
    clr(6'h20);
    chk("R9 cleared bit", 32'(sts_q[5]), 0);
    chk("R9 other bit kept", 32'(sts_q[4]), 1);

    // R11 enable off
    clr(6'h3F);
    tx_dma_en = 0; #1;
    chk("R11 tx_dma_req off when disabled", 32'(tx_dma_req), 0);

    tick();
    finish_run();
  end
endmodule